// File: doc/BRIEF.md
# Stack Machine Instruction Sequencer

This block is the control core of a small 16-bit processor whose instructions name no registers. Every instruction word carries a predicate on the flags, two operand-source selectors, a command and a selector for where the result goes. The sequencer fetches a word, tests its predicate, collects the two operands one after the other (a constant zero, an inline immediate, a read of the stack top, or a read that also pops), performs the command, and then drops the result, pushes it or jumps to it. It holds the instruction pointer, stack pointer, frame base pointer and a three-bit flag register.

All memory traffic goes through one byte-addressed port with a request/ready handshake. Words are little-endian, and a byte access returns the byte zero-extended in the low half of the read data. The sequencer takes several cycles per instruction and waits in any access state until ready is seen. One reserved command stops the core cleanly. A second reserved command, or any encoding the core does not support, stops it with an error.

Instruction layout, LSB first: bits 2:0 predicate (0 always, 1 zero clear, 2 zero set, 3 carry set, 4 negative clear); bits 4:3 operand A source and bits 6:5 operand B source (0 zero, 1 immediate, 2 peek, 3 pop); bits 8:7 result route (0 drop, 1 push, 2 jump); bit 9 update zero/negative from the result; bits 14:10 command; bit 15 must be 0. Commands: 0 copy, 1 add, 2 sub, 3 and, 4 or, 5 xor, 6 not, 7 shift left one, 8 shift right one, 9 byte swap, 10 sign-extend low byte, 11 frame read, 12 frame write, 13 byte load, 14 word load, 15 byte store, 16 word store, 17 set sp, 18 set bp, 19 read sp, 20 read bp, 21 read ip-relative, 30 halt, 31 trap. The flag output holds zero in bit 0, negative in bit 1 and carry in bit 2.

Top module: `stk_seq`

## Requirements
- R1: After reset ip, sp, bp and all flags are 0, and the first request is a word read at address 0.
- R2: Each accepted instruction fetch advances ip by 2, wrapping from 0xFFFE to 0x0000.
- R3: The predicate codes 0 to 4 select always, zero clear, zero set, carry set and negative clear; codes 5 to 7 stop the core with the illegal output.
- R4: Operand A is resolved before operand B; an immediate is read at ip and advances ip by 2, a peek reads the word at sp, a pop reads the word at sp and then adds 2 to sp.
- R5: An instruction whose predicate is false changes nothing except adding 2 to ip for each immediate source it names.
- R6: The push route first subtracts 2 from sp and then writes the result word at the new sp.
- R7: The jump route loads ip with the result; the drop route leaves ip, sp and memory untouched.
- R8: Frame read returns the word at bp + 2*A; frame write stores B there and yields B.
- R9: Byte and word loads read at address A; a word store writes B at A and yields B; a byte store writes only the low byte of B at A and yields that byte zero-extended.
- R10: Set sp and set bp load A; read sp and read bp yield the current value; read ip-relative yields ip + 2*A, with ip already past the immediates; a push after set sp starts from the new sp.
- R11: Add and sub set carry to the carry out and the borrow respectively; the logic, shift, swap and sign-extend commands compute their results as listed; with bit 9 set, zero and negative follow the result.
- R12: Command 30 under a true predicate raises halt; command 31, an unlisted command, route 3 or a set bit 15 raise illegal; both outputs are sticky and no memory request follows.
- R13: While a request waits for ready, address, direction, size and write data stay stable and no architectural register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_byte | output | 1 | 1 for byte access, 0 for word access |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data, low byte used for byte writes |
| mem_rdata | input | 16 | Read data, byte reads zero-extended |
| mem_ready | input | 1 | Completes the pending access this cycle |
| halted | output | 1 | Clean stop by the halt command |
| illegal | output | 1 | Stop on an unsupported or trap encoding |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |
| bp_o | output | 16 | Frame base pointer |
| flags_o | output | 3 | Carry, negative, zero (bit 2 to bit 0) |

## Verification
The assertions watch the handshake on every cycle: stable request fields and frozen pointers during a stall, the ip step of 2 on each fetch, the push address equal to sp, and the sticky, silent and mutually exclusive stop states. What the commands compute, the predicate decisions, the order in which pops are taken, the skip of immediates under a false predicate and the byte placement in memory can only be shown by the bench's programs, which compare final memory and register contents against arithmetic done in the bench.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int XW = 16;
  localparam int FW = 3;

  typedef struct packed {
    logic       spare;
    logic [4:0] cmd;
    logic       mf;
    logic [1:0] dst;
    logic [1:0] srcb;
    logic [1:0] srca;
    logic [2:0] cond;
  } insn_t;

  localparam logic [1:0] SRC_ZERO = 2'd0, SRC_IMM = 2'd1, SRC_PEEK = 2'd2, SRC_POP = 2'd3;
  localparam logic [1:0] DST_DROP = 2'd0, DST_PUSH = 2'd1, DST_JUMP = 2'd2;

  localparam logic [4:0] C_COPY = 5'd0, C_ADD = 5'd1, C_SUB = 5'd2, C_AND = 5'd3,
    C_OR = 5'd4, C_XOR = 5'd5, C_NOT = 5'd6, C_SHL = 5'd7, C_SHR = 5'd8,
    C_SWAP = 5'd9, C_SEXT = 5'd10, C_FRD = 5'd11, C_FWR = 5'd12, C_LDB = 5'd13,
    C_LDW = 5'd14, C_STB = 5'd15, C_STW = 5'd16, C_SPS = 5'd17, C_BPS = 5'd18,
    C_SPG = 5'd19, C_BPG = 5'd20, C_IPR = 5'd21, C_HALT = 5'd30, C_TRAP = 5'd31;
  localparam logic [4:0] C_LAST = C_IPR;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DEC, ST_OPA, ST_OPB, ST_EXE, ST_PUSH, ST_HALT, ST_ILL
  } st_t;
endpackage

// File: rtl/stk_cond.sv
module stk_cond
  import stk_pkg::*;
(
  input  logic [2:0]    cond,
  input  logic [FW-1:0] flags,
  output logic          known,
  output logic          take
);
  always_comb begin
    known = 1'b1;
    case (cond)
      3'd0:    take = 1'b1;
      3'd1:    take = !flags[0];
      3'd2:    take = flags[0];
      3'd3:    take = flags[2];
      3'd4:    take = !flags[1];
      default: begin take = 1'b0; known = 1'b0; end
    endcase
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
(
  input  logic [4:0]    cmd,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y,
  output logic          cy
);
  localparam int HW = XW / 2;
  logic [XW:0] sum, dif;
  assign sum = {1'b0, a} + {1'b0, b};
  assign dif = {1'b0, a} - {1'b0, b};
  always_comb begin
    cy = 1'b0;
    case (cmd)
      C_ADD:   begin y = sum[XW-1:0]; cy = sum[XW]; end
      C_SUB:   begin y = dif[XW-1:0]; cy = dif[XW]; end
      C_AND:   y = a & b;
      C_OR:    y = a | b;
      C_XOR:   y = a ^ b;
      C_NOT:   y = ~a;
      C_SHL:   y = a << 1;
      C_SHR:   y = a >> 1;
      C_SWAP:  y = {a[HW-1:0], a[XW-1:HW]};
      C_SEXT:  y = {{HW{a[HW-1]}}, a[HW-1:0]};
      default: y = a;
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_byte,
  output logic [15:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          halted,
  output logic          illegal,
  output logic [15:0]   ip_o,
  output logic [15:0]   sp_o,
  output logic [15:0]   bp_o,
  output logic [2:0]    flags_o
);
  localparam logic [XW-1:0] STEP = XW'(2);

  logic rst_m, rst_s_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rst_s_n, rst_m} <= 2'b00;
    else        {rst_s_n, rst_m} <= {rst_m, 1'b1};

  st_t st_q, st_d;
  insn_t ir_q, ir_d;
  logic [XW-1:0] ip_q, ip_d, sp_q, sp_d, bp_q, bp_d;
  logic [XW-1:0] opa_q, opa_d, opb_q, opb_d, res_q, res_d;
  logic [FW-1:0] fl_q, fl_d;

  logic known, take, alu_cy, go, mem_cmd;
  logic [XW-1:0] alu_y, res, sp_base;
  logic [1:0] src, n_imm;
  logic in_fetch, in_push;

  stk_cond u_cond (.cond(ir_q.cond), .flags(fl_q), .known(known), .take(take));
  stk_alu  u_alu  (.cmd(ir_q.cmd), .a(opa_q), .b(opb_q), .y(alu_y), .cy(alu_cy));

  assign n_imm   = {1'b0, ir_q.srca == SRC_IMM} + {1'b0, ir_q.srcb == SRC_IMM};
  assign src     = (st_q == ST_OPA) ? ir_q.srca : ir_q.srcb;
  assign mem_cmd = ir_q.cmd >= C_FRD && ir_q.cmd <= C_STW;
  assign sp_base = (ir_q.cmd == C_SPS) ? opa_q : sp_q;

  always_comb begin
    case (ir_q.cmd)
      C_FRD, C_LDW: res = mem_rdata;
      C_LDB:        res = {8'h00, mem_rdata[7:0]};
      C_FWR, C_STW: res = opb_q;
      C_STB:        res = {8'h00, opb_q[7:0]};
      C_SPS, C_BPS: res = opa_q;
      C_SPG:        res = sp_q;
      C_BPG:        res = bp_q;
      C_IPR:        res = ip_q + (opa_q << 1);
      default:      res = alu_y;
    endcase
  end

  always_comb begin
    st_d = st_q; ir_d = ir_q; ip_d = ip_q; sp_d = sp_q; bp_d = bp_q;
    opa_d = opa_q; opb_d = opb_q; res_d = res_q; fl_d = fl_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_byte = 1'b0;
    mem_addr = ip_q; mem_wdata = '0; go = 1'b0;
    case (st_q)
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          ir_d = insn_t'(mem_rdata);
          ip_d = ip_q + STEP;
          st_d = ST_DEC;
        end
      end
      ST_DEC: begin
        if (!known || ir_q.spare) st_d = ST_ILL;
        else if (!take) begin
          ip_d = ip_q + {13'd0, n_imm, 1'b0};
          st_d = ST_FETCH;
        end
        else if (ir_q.cmd == C_HALT) st_d = ST_HALT;
        else if (ir_q.cmd > C_LAST || ir_q.dst == 2'd3) st_d = ST_ILL;
        else st_d = ST_OPA;
      end
      ST_OPA, ST_OPB: begin
        if (src == SRC_ZERO) go = 1'b1;
        else begin
          mem_req  = 1'b1;
          mem_addr = (src == SRC_IMM) ? ip_q : sp_q;
          go       = mem_ready;
        end
        if (go) begin
          if (src != SRC_ZERO && mem_ready) begin
            if (src == SRC_IMM) ip_d = ip_q + STEP;
            if (src == SRC_POP) sp_d = sp_q + STEP;
          end
          if (st_q == ST_OPA) begin
            opa_d = (src == SRC_ZERO) ? '0 : mem_rdata;
            st_d  = ST_OPB;
          end else begin
            opb_d = (src == SRC_ZERO) ? '0 : mem_rdata;
            st_d  = ST_EXE;
          end
        end
      end
      ST_EXE: begin
        if (mem_cmd) begin
          mem_req   = 1'b1;
          mem_addr  = (ir_q.cmd == C_FRD || ir_q.cmd == C_FWR) ? bp_q + (opa_q << 1) : opa_q;
          mem_we    = ir_q.cmd == C_FWR || ir_q.cmd == C_STB || ir_q.cmd == C_STW;
          mem_byte  = ir_q.cmd == C_LDB || ir_q.cmd == C_STB;
          mem_wdata = opb_q;
          go        = mem_ready;
        end else go = 1'b1;
        if (go) begin
          if (ir_q.cmd == C_ADD || ir_q.cmd == C_SUB) fl_d[2] = alu_cy;
          if (ir_q.mf) begin
            fl_d[0] = res == '0;
            fl_d[1] = res[XW-1];
          end
          if (ir_q.cmd == C_SPS) sp_d = opa_q;
          if (ir_q.cmd == C_BPS) bp_d = opa_q;
          st_d = ST_FETCH;
          if (ir_q.dst == DST_PUSH) begin
            sp_d  = sp_base - STEP;
            res_d = res;
            st_d  = ST_PUSH;
          end
          if (ir_q.dst == DST_JUMP) ip_d = res;
        end
      end
      ST_PUSH: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_q; mem_wdata = res_q;
        if (mem_ready) st_d = ST_FETCH;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_FETCH; ir_q <= '0; ip_q <= '0; sp_q <= '0; bp_q <= '0;
      opa_q <= '0; opb_q <= '0; res_q <= '0; fl_q <= '0;
    end else begin
      st_q <= st_d; ir_q <= ir_d; ip_q <= ip_d; sp_q <= sp_d; bp_q <= bp_d;
      opa_q <= opa_d; opb_q <= opb_d; res_q <= res_d; fl_q <= fl_d;
    end
  end

  assign in_fetch = st_q == ST_FETCH;
  assign in_push  = st_q == ST_PUSH;
  assign halted   = st_q == ST_HALT;
  assign illegal  = st_q == ST_ILL;
  assign ip_o = ip_q;
  assign sp_o = sp_q;
  assign bp_o = bp_q;
  assign flags_o = fl_q;
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_byte,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ready,
  input logic        halted,
  input logic        illegal,
  input logic [15:0] ip_o,
  input logic [15:0] sp_o,
  input logic [15:0] bp_o,
  input logic        in_fetch,
  input logic        in_push
);
  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_byte) && $stable(mem_wdata));
  assert_stall_regs_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> $stable(ip_o) && $stable(sp_o) && $stable(bp_o));
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch && mem_ready |=> ip_o == $past(ip_o) + 16'd2);
  assert_push_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_push |-> mem_req && mem_we && !mem_byte && mem_addr == sp_o);
  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_illegal_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
  assert_stop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted || illegal |-> !mem_req);
  assert_stop_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && illegal));
endmodule

bind stk_seq stk_seq_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .halted(halted), .illegal(illegal), .ip_o(ip_o),
  .sp_o(sp_o), .bp_o(bp_o), .in_fetch(in_fetch), .in_push(in_push)
);

// File: tb/test_stk_seq.sv
module test_stk_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_req, mem_we, mem_byte, mem_ready, halted, illegal;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, ip_o, sp_o, bp_o;
  logic [2:0] flags_o;
  logic [7:0] mem [0:255];
  logic [3:0] rcnt = 4'd0;
  logic hold_off = 1'b0;
  int nchk = 0, nfail = 0;
  logic [7:0] wp;

  always #10 clk = ~clk;

  stk_seq i_stk_seq (.clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .halted(halted), .illegal(illegal),
    .ip_o(ip_o), .sp_o(sp_o), .bp_o(bp_o), .flags_o(flags_o));

  always @(negedge clk) rcnt <= rcnt + 4'd1;
  assign mem_ready = !hold_off && (rcnt[1:0] != 2'd3);
  always_comb begin
    mem_rdata = mem_byte ? {8'h00, mem[mem_addr[7:0]]}
                         : {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
  end
  always @(posedge clk)
    if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (!mem_byte) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
    end

  function automatic logic [15:0] enc(input logic [4:0] cmd, input logic [1:0] sa,
      input logic [1:0] sb, input logic [1:0] dst, input logic mf, input logic [2:0] cnd);
    return {1'b0, cmd, mf, dst, sb, sa, cnd};
  endfunction

  function automatic logic [15:0] rd16(input logic [7:0] a);
    return {mem[a + 8'd1], mem[a]};
  endfunction

  function automatic logic [16:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    int unsigned s;
    case (op)
      1: begin s = a + b; return {s > 32'hFFFF, s[15:0]}; end
      2: return {a < b, 16'(a - b)};
      3: return {1'b0, a & b};
      4: return {1'b0, a | b};
      5: return {1'b0, a ^ b};
      6: return {1'b0, ~a};
      7: return {1'b0, 16'(a * 2)};
      8: return {1'b0, 16'(a / 2)};
      9: return {1'b0, 16'(a % 256) * 16'd256 + 16'(a / 256)};
      10: return {1'b0, (a[7] ? 16'hFF00 : 16'h0000) + 16'(a % 256)};
      default: return {1'b0, a};
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic begin_prog();
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    wp = 8'h00;
  endtask

  task automatic emit(input logic [15:0] w);
    mem[wp] = w[7:0]; mem[wp + 8'd1] = w[15:8]; wp = wp + 8'd2;
  endtask

  task automatic run();
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted || illegal) break;
    end
  endtask

  localparam logic [1:0] Z = 2'd0, I = 2'd1, PK = 2'd2, PP = 2'd3;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [15:0] va [0:7];
    va[0] = 16'h0000; va[1] = 16'h0001; va[2] = 16'hFFFF; va[3] = 16'h8000;
    va[4] = 16'h7FFF; va[5] = 16'h1234; va[6] = 16'h00F0; va[7] = 16'hA5C3;

    // R1 reset state and R13 stall with ready held low
    begin_prog();
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    hold_off = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 ip", ip_o, 16'h0); chk("R1 sp", sp_o, 16'h0); chk("R1 bp", bp_o, 16'h0);
    chk("R1 flags", {13'd0, flags_o}, 16'h0);
    chk("R1 req", {15'd0, mem_req}, 16'h1); chk("R1 addr", mem_addr, 16'h0);
    chk("R1 we", {14'd0, mem_we, mem_byte}, 16'h0);
    repeat (20) @(negedge clk);
    chk("R13 stalled ip", ip_o, 16'h0); chk("R13 stalled req", {15'd0, mem_req}, 16'h1);
    hold_off = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 halt", {14'd0, halted, illegal}, 16'h2); chk("R2 ip after halt", ip_o, 16'h2);

    // R11 sweep of ALU commands with immediates and push (R4, R6)
    for (int op = 0; op <= 10; op++)
      for (int k = 0; k < 8; k++) begin
        logic [16:0] e;
        logic [15:0] b;
        b = va[(k + 3) % 8];
        e = model(op, va[k], b);
        begin_prog();
        emit(enc(5'(op), I, I, 2'd1, 1'b1, 3'd0)); emit(va[k]); emit(b);
        emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
        run();
        chk($sformatf("R11 op%0d result", op), rd16(8'hFE), e[15:0]);
        chk($sformatf("R11 op%0d flags", op), {13'd0, flags_o},
            {13'd0, e[16], e[15], e[15:0] == 16'h0});
        chk("R6 sp after push", sp_o, 16'hFFFE);
        chk("R4 ip past immediates", ip_o, 16'h8);
      end

    // R3 and R5: predicates against flags from a prior add
    for (int f = 0; f < 5; f++)
      for (int c = 0; c < 5; c++) begin
        logic [15:0] a, b, r;
        logic zf, nf, cf, p;
        case (f)
          0: begin a = 16'h0000; b = 16'h0000; end
          1: begin a = 16'h0001; b = 16'h0000; end
          2: begin a = 16'h8000; b = 16'h0000; end
          3: begin a = 16'hFFFF; b = 16'h0001; end
          default: begin a = 16'hFFFF; b = 16'h8001; end
        endcase
        r = a + b; zf = r == 16'h0; nf = r[15]; cf = (32'(a) + 32'(b)) > 32'hFFFF;
        case (c) 0: p = 1'b1; 1: p = !zf; 2: p = zf; 3: p = cf; default: p = !nf; endcase
        begin_prog();
        emit(enc(5'd1, I, I, 2'd0, 1'b1, 3'd0)); emit(a); emit(b);
        emit(enc(5'd0, I, Z, 2'd1, 1'b0, 3'(c))); emit(16'h0055);
        emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
        run();
        chk($sformatf("R3 cond%0d sp", c), sp_o, p ? 16'hFFFE : 16'h0000);
        if (p) chk("R3 pushed", rd16(8'hFE), 16'h0055);
        chk("R5 ip after skip", ip_o, 16'd12);
      end

    // R3: unsupported predicate codes
    for (int c = 5; c < 8; c++) begin
      begin_prog();
      emit(enc(5'd0, Z, Z, 2'd0, 1'b0, 3'(c)));
      run();
      chk("R3 bad cond illegal", {14'd0, halted, illegal}, 16'h1);
      chk("R3 bad cond ip", ip_o, 16'h2);
    end

    // R12: halt under false predicate skipped, then trap; route 3; unlisted command
    begin_prog();
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd2));
    emit(enc(5'd31, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R12 trap after skipped halt", {14'd0, halted, illegal}, 16'h1);
    chk("R12 trap ip", ip_o, 16'h4);
    begin_prog();
    emit(enc(5'd0, Z, Z, 2'd3, 1'b0, 3'd0));
    run();
    chk("R12 route3", {14'd0, halted, illegal}, 16'h1);
    begin_prog();
    emit(enc(5'd25, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R12 unlisted", {14'd0, halted, illegal}, 16'h1);
    repeat (5) @(negedge clk);
    chk("R12 quiet", {15'd0, mem_req}, 16'h0);

    // R4: pop order, peek
    begin_prog();
    emit(enc(5'd0, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'd5);
    emit(enc(5'd0, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'd3);
    emit(enc(5'd2, PP, PP, 2'd1, 1'b0, 3'd0));
    emit(enc(5'd0, PK, Z, 2'd1, 1'b0, 3'd0));
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R4 sp", sp_o, 16'hFFFC);
    chk("R4 pop order", rd16(8'hFE), 16'hFFFE);
    chk("R4 peek copy", rd16(8'hFC), 16'hFFFE);
    chk("R11 borrow", {13'd0, flags_o}, 16'h4);

    // R9: byte and word loads and stores
    begin_prog();
    emit(enc(5'd16, I, I, 2'd0, 1'b0, 3'd0)); emit(16'h0040); emit(16'hA1B2);
    emit(enc(5'd15, I, I, 2'd1, 1'b0, 3'd0)); emit(16'h0043); emit(16'h1234);
    emit(enc(5'd14, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'h0042);
    emit(enc(5'd13, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'h0041);
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R9 store16", rd16(8'h40), 16'hA1B2);
    chk("R9 store8 yield", rd16(8'hFE), 16'h0034);
    chk("R9 load16", rd16(8'hFC), 16'h3400);
    chk("R9 load8", rd16(8'hFA), 16'h00A1);
    chk("R9 byte only", {8'h00, mem[8'h44]}, 16'h0000);
    chk("R9 sp", sp_o, 16'hFFFA);

    // R8, R10: frame access and pointer commands
    begin_prog();
    emit(enc(5'd18, I, Z, 2'd0, 1'b0, 3'd0)); emit(16'h0080);
    emit(enc(5'd12, I, I, 2'd1, 1'b0, 3'd0)); emit(16'd3); emit(16'hBEEF);
    emit(enc(5'd11, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'd3);
    emit(enc(5'd20, Z, Z, 2'd1, 1'b0, 3'd0));
    emit(enc(5'd19, Z, Z, 2'd1, 1'b0, 3'd0));
    emit(enc(5'd21, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'd2);
    emit(enc(5'd17, I, Z, 2'd0, 1'b0, 3'd0)); emit(16'h0060);
    emit(enc(5'd0, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'd7);
    emit(enc(5'd17, I, Z, 2'd1, 1'b0, 3'd0)); emit(16'h0070);
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R8 set mem", rd16(8'h86), 16'hBEEF);
    chk("R8 set yield", rd16(8'hFE), 16'hBEEF);
    chk("R8 get", rd16(8'hFC), 16'hBEEF);
    chk("R10 bpget", rd16(8'hFA), 16'h0080);
    chk("R10 spget", rd16(8'hF8), 16'hFFFA);
    chk("R10 ipget", rd16(8'hF6), 16'h001A);
    chk("R10 spset push", rd16(8'h5E), 16'h0007);
    chk("R10 spset then push", rd16(8'h6E), 16'h0070);
    chk("R10 sp", sp_o, 16'h006E);
    chk("R10 bp", bp_o, 16'h0080);

    // R7: absolute and relative jumps, drop route
    begin_prog();
    emit(enc(5'd0, I, Z, 2'd2, 1'b0, 3'd0)); emit(16'h0020);
    emit(16'hFFFF);
    wp = 8'h20;
    emit(enc(5'd0, I, Z, 2'd0, 1'b0, 3'd0)); emit(16'd9);
    emit(enc(5'd21, I, Z, 2'd2, 1'b0, 3'd0)); emit(16'd3);
    emit(16'hFFFF);
    wp = 8'h2E;
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R7 jumps reach halt", {14'd0, halted, illegal}, 16'h2);
    chk("R7 ip", ip_o, 16'h0030);
    chk("R7 drop sp", sp_o, 16'h0000);
    chk("R7 drop mem", rd16(8'hFE), 16'h0000);

    // R2: fetch wrap at the top of the address space
    begin_prog();
    emit(enc(5'd0, I, Z, 2'd2, 1'b0, 3'd0)); emit(16'hFFFE);
    wp = 8'hFE;
    emit(enc(5'd30, Z, Z, 2'd0, 1'b0, 3'd0));
    run();
    chk("R2 wrap halted", {15'd0, halted}, 16'h1);
    chk("R2 wrap ip", ip_o, 16'h0000);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule